// File: doc/BRIEF.md
# Cell Reassembly and VC-Merge Unit

This block sits on one output port of a cell switch whose buffering is at the outputs. It receives at most one cell per clock. Each cell comes with the number of the input port it entered on, a local incoming-circuit number, a 3-bit payload-type field and a payload word. The pair {input port, local circuit} picks one of several logical reassembly queues. A cell stays in its queue until the cell that closes its AAL5 packet arrives. Cells are never cut through early.

When a packet completes, its whole chain of cells is linked onto the tail of a single FIFO output queue in one step, so the run stays contiguous. In that same step every cell of the packet takes on the outgoing VCI held in a translation table for its queue. Many incoming circuits can share one outgoing label, and their packets still never interleave. All cells sit in one shared pool, and a map of occupied slots tracks which slots are in use. The output side uses a valid/ready handshake.

A circuit whose table entry is not marked valid has its cells discarded. If a cell arrives when no slot is free, its packet is abandoned. The slots the packet already holds go back to the pool, and the rest of the packet is discarded up to and including its end cell.

Top module: `vcm_reasm_merge`

## Requirements
- R1: After reset `out_valid` is 0 and `drop_cnt` is 0.
- R2: No cell of a packet is offered on the output while the packet's end cell has not yet arrived.
- R3: A cell ends its packet when bit 0 of `in_pt` is 1. If the output queue is empty, `out_valid` is 1 at the first clock edge after the end cell is taken, and the packet's first cell is on the output.
- R4: Every output cell carries `out_vci` equal to the table entry of queue index {`in_port`,`in_vc`} (port in the upper bits). Two queues with the same entry both leave on that one VCI.
- R5: Packets from circuits whose cells arrive interleaved leave as contiguous runs, in the order in which their end cells arrived.
- R6: The output queue is FIFO. While `out_ready` is 0, `out_valid`, `out_payload`, `out_pt` and `out_vci` hold their values.
- R7: Cells on a queue whose table entry has its valid bit at 0 produce no output and do not change `drop_cnt`.
- R8: A cell that finds no free slot causes its packet to be dropped. `drop_cnt` rises by exactly 1, the cells of that packet already held are released, and the later cells of that packet up to its end cell are discarded. The next packet on that circuit is carried normally.
- R9: `out_payload` and `out_pt` equal the values that cell had at the input.
- R10: The same `in_vc` on two different input ports selects two separate queues. Their packets do not mix even when their cells interleave.
- R11: Drained slots return to the pool. Once the output has drained, a packet of exactly DEPTH cells is accepted whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cell is present this cycle |
| in_port | input | PORT_W | Input port the cell came from |
| in_vc | input | LVC_W | Local incoming circuit number |
| in_pt | input | 3 | Payload-type field; bit 0 marks packet end |
| in_payload | input | PAY_W | Cell body |
| out_ready | input | 1 | Downstream takes the output cell |
| out_valid | output | 1 | Output queue holds a cell |
| out_vci | output | VCI_W | Rewritten outgoing VCI |
| out_pt | output | 3 | Payload type of output cell |
| out_payload | output | PAY_W | Body of output cell |
| tbl_we | input | 1 | Translation table write strobe |
| tbl_addr | input | PORT_W+LVC_W | Queue index to write |
| tbl_vci | input | VCI_W | Outgoing VCI to store |
| tbl_ok | input | 1 | Valid bit to store for that queue |
| drop_cnt | output | DROP_W | Count of packets dropped for lack of space |

## Verification
The assertions assume that the translation table is not rewritten for a queue while that queue holds a partial packet. The bench loads every entry before it sends any traffic and never changes an entry afterwards. They also assume that the drop counter moves at most once per cycle, which holds because only one cell arrives per cycle. The stimulus therefore presents at most one cell per clock and drives inputs shortly after the rising edge. The hold check on the output rests on `out_ready` changing only between edges, which the bench also keeps to.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
    localparam int PT_W       = 3;
    localparam int PT_END_BIT = 0;

    function automatic logic is_last(input logic [PT_W-1:0] pt);
        return pt[PT_END_BIT];
    endfunction
endpackage

// File: rtl/vcm_free_pick.sv
module vcm_free_pick #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] used,
    output logic             any_free,
    output logic [AW-1:0]    idx
);
    // lowest-numbered free slot
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!used[i]) begin
                any_free = 1'b1;
                idx      = AW'(i);
            end
        end
    end
endmodule

// File: rtl/vcm_xlate.sv
module vcm_xlate #(
    parameter int QW    = 3,
    parameter int VCI_W = 16,
    parameter int NQ    = 1 << QW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [QW-1:0]    waddr,
    input  logic [VCI_W-1:0] wvci,
    input  logic             wok,
    input  logic [QW-1:0]    raddr,
    output logic [VCI_W-1:0] rvci,
    output logic             rok
);
    logic [VCI_W-1:0] vci_d [NQ];
    logic [VCI_W-1:0] vci_q [NQ];
    logic [NQ-1:0]    ok_d, ok_q;

    always_comb begin
        vci_d = vci_q;
        ok_d  = ok_q;
        if (we) begin
            vci_d[waddr] = wvci;
            ok_d[waddr]  = wok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q  <= '0;
            vci_q <= '{default: '0};
        end else begin
            ok_q  <= ok_d;
            vci_q <= vci_d;
        end
    end

    assign rvci = vci_q[raddr];
    assign rok  = ok_q[raddr];
endmodule

// File: rtl/vcm_reasm_merge.sv
module vcm_reasm_merge #(
    parameter int PORT_W = 1,
    parameter int LVC_W  = 2,
    parameter int DEPTH  = 16,
    parameter int PAY_W  = 32,
    parameter int VCI_W  = 16,
    parameter int DROP_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [PORT_W-1:0]             in_port,
    input  logic [LVC_W-1:0]              in_vc,
    input  logic [vcm_pkg::PT_W-1:0]      in_pt,
    input  logic [PAY_W-1:0]              in_payload,
    input  logic                          out_ready,
    output logic                          out_valid,
    output logic [VCI_W-1:0]              out_vci,
    output logic [vcm_pkg::PT_W-1:0]      out_pt,
    output logic [PAY_W-1:0]              out_payload,
    input  logic                          tbl_we,
    input  logic [PORT_W+LVC_W-1:0]       tbl_addr,
    input  logic [VCI_W-1:0]              tbl_vci,
    input  logic                          tbl_ok,
    output logic [DROP_W-1:0]             drop_cnt
);
    localparam int QW   = PORT_W + LVC_W;
    localparam int NQ   = 1 << QW;
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = AW + 1;
    localparam int PT_W = vcm_pkg::PT_W;

    typedef struct {
        logic [DEPTH-1:0]  used;          // slot holds a cell
        logic [DEPTH-1:0]  inq;           // slot is linked in the output queue
        logic [QW-1:0]     own  [DEPTH];
        logic [AW-1:0]     nxt  [DEPTH];
        logic [PAY_W-1:0]  pay  [DEPTH];
        logic [PT_W-1:0]   pt   [DEPTH];
        logic [VCI_W-1:0]  vci  [DEPTH];
        logic [AW-1:0]     qh   [NQ];
        logic [AW-1:0]     qt   [NQ];
        logic [CW-1:0]     qc   [NQ];
        logic [NQ-1:0]     disc;          // discarding rest of a dropped packet
        logic [AW-1:0]     oh, ot;
        logic [CW-1:0]     oc;
        logic [DROP_W-1:0] drops;
    } st_t;

    st_t s_d, s_q;

    logic [QW-1:0]    qi;
    logic             last, pop, any_free, t_ok;
    logic [AW-1:0]    fidx, hd;
    logic [CW-1:0]    add;
    logic [VCI_W-1:0] t_vci;

    assign qi = {in_port, in_vc};

    vcm_free_pick #(.DEPTH(DEPTH), .AW(AW)) i_pick (
        .used(s_q.used), .any_free(any_free), .idx(fidx)
    );

    vcm_xlate #(.QW(QW), .VCI_W(VCI_W), .NQ(NQ)) i_xlate (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr),
        .wvci(tbl_vci), .wok(tbl_ok), .raddr(qi), .rvci(t_vci), .rok(t_ok)
    );

    assign out_valid   = (s_q.oc != '0);
    assign out_vci     = s_q.vci[s_q.oh];
    assign out_pt      = s_q.pt[s_q.oh];
    assign out_payload = s_q.pay[s_q.oh];
    assign drop_cnt    = s_q.drops;

    always_comb begin
        s_d  = s_q;
        pop  = out_valid && out_ready;
        last = vcm_pkg::is_last(in_pt);
        hd   = (s_q.qc[qi] != '0) ? s_q.qh[qi] : fidx;
        add  = '0;

        if (pop) begin
            s_d.used[s_q.oh] = 1'b0;
            s_d.inq[s_q.oh]  = 1'b0;
            s_d.oh           = s_q.nxt[s_q.oh];
        end

        if (in_valid && t_ok) begin
            if (s_q.disc[qi]) begin
                if (last) s_d.disc[qi] = 1'b0;
            end else if (!any_free) begin
                // abandon packet: release every held slot of this queue
                for (int i = 0; i < DEPTH; i++) begin
                    if (s_q.used[i] && !s_q.inq[i] && s_q.own[i] == qi)
                        s_d.used[i] = 1'b0;
                end
                s_d.qc[qi]   = '0;
                s_d.drops    = s_q.drops + DROP_W'(1);
                s_d.disc[qi] = !last;
            end else begin
                s_d.used[fidx] = 1'b1;
                s_d.own[fidx]  = qi;
                s_d.pay[fidx]  = in_payload;
                s_d.pt[fidx]   = in_pt;
                if (s_q.qc[qi] != '0) s_d.nxt[s_q.qt[qi]] = fidx;
                if (!last) begin
                    s_d.qh[qi] = hd;
                    s_d.qt[qi] = fidx;
                    s_d.qc[qi] = s_q.qc[qi] + CW'(1);
                end else begin
                    // splice whole chain onto the output queue, rewriting VCI
                    for (int i = 0; i < DEPTH; i++) begin
                        if (s_q.used[i] && !s_q.inq[i] && s_q.own[i] == qi) begin
                            s_d.inq[i] = 1'b1;
                            s_d.vci[i] = t_vci;
                        end
                    end
                    s_d.inq[fidx] = 1'b1;
                    s_d.vci[fidx] = t_vci;
                    s_d.qc[qi]    = '0;
                    add           = s_q.qc[qi] + CW'(1);
                    if (s_q.oc == CW'(pop)) s_d.oh = hd;
                    else                    s_d.nxt[s_q.ot] = hd;
                    s_d.ot = fidx;
                end
            end
        end

        s_d.oc = s_q.oc - CW'(pop) + add;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.used  <= '0;
            s_q.inq   <= '0;
            s_q.qc    <= '{default: '0};
            s_q.disc  <= '0;
            s_q.oh    <= '0;
            s_q.ot    <= '0;
            s_q.oc    <= '0;
            s_q.drops <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: output count equals the slots linked as complete
    a_r2_only_complete_out: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.oc) == $countones(s_q.inq));

    // R3: a valid output head is a slot of a completed packet
    a_r3_head_complete: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> s_q.inq[s_q.oh]);

    // R6: stalled output holds its cell
    a_r6_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_payload)
                                   && $stable(out_vci) && $stable(out_pt));

    // R8: at most one drop per cycle
    a_r8_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + DROP_W'(1));

    // R11: every slot in the output queue is an occupied slot
    a_r11_queued_is_used: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.inq & ~s_q.used) == '0);
endmodule

// File: tb/test_vcm_reasm_merge.sv
module test_vcm_reasm_merge;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [0:0]  in_port = '0;
    logic [1:0]  in_vc = '0;
    logic [2:0]  in_pt = '0;
    logic [31:0] in_payload = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [15:0] out_vci;
    logic [2:0]  out_pt;
    logic [31:0] out_payload;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_addr = '0;
    logic [15:0] tbl_vci = '0;
    logic        tbl_ok = 1'b0;
    logic [15:0] drop_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [50:0] exp_c [512];
    logic [50:0] cap_c [512];
    int exp_n = 0;
    int cap_n = 0;
    int chk_i = 0;

    always #2 clk = ~clk;

    vcm_reasm_merge i_vcm_reasm_merge (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
        .in_vc(in_vc), .in_pt(in_pt), .in_payload(in_payload),
        .out_ready(out_ready), .out_valid(out_valid), .out_vci(out_vci),
        .out_pt(out_pt), .out_payload(out_payload), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_vci(tbl_vci), .tbl_ok(tbl_ok),
        .drop_cnt(drop_cnt)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && cap_n < 512) begin
            cap_c[cap_n] = {out_vci, out_pt, out_payload};
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_tbl(input logic [2:0] a, input logic [15:0] v, input logic ok);
        tbl_we = 1'b1; tbl_addr = a; tbl_vci = v; tbl_ok = ok;
        @(posedge clk); #1;
        tbl_we = 1'b0;
    endtask

    task automatic send(input logic p, input logic [1:0] vc, input logic [2:0] pt,
                        input logic [31:0] pay);
        in_valid = 1'b1; in_port = p; in_vc = vc; in_pt = pt; in_payload = pay;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic expect_cell(input logic [15:0] v, input logic [2:0] pt,
                               input logic [31:0] pay);
        exp_c[exp_n] = {v, pt, pay};
        exp_n++;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic compare_out(input string req);
        idle(40);
        chk(cap_n == exp_n, req, "cell count", 64'(cap_n), 64'(exp_n));
        for (int i = chk_i; i < exp_n && i < cap_n; i++)
            chk(cap_c[i] == exp_c[i], req, "cell vci/pt/payload",
                64'(cap_c[i]), 64'(exp_c[i]));
        chk_i = exp_n;
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 0);
        chk(drop_cnt == 16'd0, "R1", "drop_cnt after reset", 64'(drop_cnt), 0);
    endtask

    task automatic t_basic;
        out_ready = 1'b1;
        send(0, 0, 3'b000, 32'hA000_0001);
        send(0, 0, 3'b010, 32'hA000_0002);
        chk(out_valid == 1'b0, "R2", "no cut-through", 64'(out_valid), 0);
        send(0, 0, 3'b011, 32'hA000_0003);
        chk(out_valid == 1'b1, "R3", "valid one edge after end cell", 64'(out_valid), 1);
        chk(out_payload == 32'hA000_0001, "R3", "first cell at head", 64'(out_payload), 64'h A0000001);
        expect_cell(16'h0100, 3'b000, 32'hA000_0001);
        expect_cell(16'h0100, 3'b010, 32'hA000_0002);
        expect_cell(16'h0100, 3'b011, 32'hA000_0003);
        compare_out("R9 R4");
    endtask

    task automatic t_merge_interleave;
        out_ready = 1'b1;
        send(0, 0, 3'b000, 32'hB000_0001);
        send(0, 1, 3'b000, 32'hC000_0001);
        send(0, 0, 3'b000, 32'hB000_0002);
        send(0, 1, 3'b001, 32'hC000_0002);
        send(0, 0, 3'b001, 32'hB000_0003);
        expect_cell(16'h0100, 3'b000, 32'hC000_0001);
        expect_cell(16'h0100, 3'b001, 32'hC000_0002);
        expect_cell(16'h0100, 3'b000, 32'hB000_0001);
        expect_cell(16'h0100, 3'b000, 32'hB000_0002);
        expect_cell(16'h0100, 3'b001, 32'hB000_0003);
        compare_out("R5 R4 merge");
    endtask

    task automatic t_ports;
        out_ready = 1'b1;
        send(1, 0, 3'b000, 32'hD100_0001);
        send(0, 0, 3'b000, 32'hD000_0001);
        send(1, 0, 3'b001, 32'hD100_0002);
        send(0, 0, 3'b001, 32'hD000_0002);
        expect_cell(16'h0200, 3'b000, 32'hD100_0001);
        expect_cell(16'h0200, 3'b001, 32'hD100_0002);
        expect_cell(16'h0100, 3'b000, 32'hD000_0001);
        expect_cell(16'h0100, 3'b001, 32'hD000_0002);
        compare_out("R10");
    endtask

    task automatic t_fifo_hold;
        out_ready = 1'b0;
        send(0, 2, 3'b000, 32'hE200_0001);
        send(0, 2, 3'b001, 32'hE200_0002);
        send(0, 0, 3'b001, 32'hE000_0001);
        idle(3);
        chk(out_valid == 1'b1, "R6", "valid while stalled", 64'(out_valid), 1);
        chk(out_payload == 32'hE200_0001, "R6", "head held", 64'(out_payload), 64'hE2000001);
        chk(out_vci == 16'h0300, "R6", "head vci held", 64'(out_vci), 64'h0300);
        idle(5);
        chk(out_payload == 32'hE200_0001, "R6", "head still held", 64'(out_payload), 64'hE2000001);
        out_ready = 1'b1;
        expect_cell(16'h0300, 3'b000, 32'hE200_0001);
        expect_cell(16'h0300, 3'b001, 32'hE200_0002);
        expect_cell(16'h0100, 3'b001, 32'hE000_0001);
        compare_out("R6 FIFO");
    endtask

    task automatic t_invalid;
        logic [15:0] d0;
        out_ready = 1'b1;
        d0 = drop_cnt;
        send(0, 3, 3'b000, 32'hF300_0001);
        send(0, 3, 3'b001, 32'hF300_0002);
        idle(4);
        chk(out_valid == 1'b0, "R7", "no output on invalid entry", 64'(out_valid), 0);
        chk(drop_cnt == d0, "R7", "drop_cnt unchanged", 64'(drop_cnt), 64'(d0));
        compare_out("R7");
    endtask

    task automatic t_overflow;
        out_ready = 1'b1;
        for (int k = 0; k < DEPTH; k++) send(0, 0, 3'b000, 32'h9000_0000 + 32'(k));
        chk(drop_cnt == 16'd0, "R8", "no drop while pool fits", 64'(drop_cnt), 0);
        send(0, 0, 3'b000, 32'h9000_00FF);
        chk(drop_cnt == 16'd1, "R8", "drop on full pool", 64'(drop_cnt), 1);
        send(0, 0, 3'b000, 32'h9000_0100);
        send(0, 0, 3'b001, 32'h9000_0101);
        idle(4);
        chk(out_valid == 1'b0, "R8", "dropped packet not output", 64'(out_valid), 0);
        chk(drop_cnt == 16'd1, "R8", "one count per packet", 64'(drop_cnt), 1);
        send(0, 0, 3'b000, 32'h9100_0001);
        send(0, 0, 3'b001, 32'h9100_0002);
        expect_cell(16'h0100, 3'b000, 32'h9100_0001);
        expect_cell(16'h0100, 3'b001, 32'h9100_0002);
        compare_out("R8 recovery");
    endtask

    task automatic t_full_packet;
        out_ready = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            send(0, 1, (k == DEPTH - 1) ? 3'b001 : 3'b000, 32'h8000_0000 + 32'(k));
            expect_cell(16'h0100, (k == DEPTH - 1) ? 3'b001 : 3'b000, 32'h8000_0000 + 32'(k));
        end
        chk(drop_cnt == 16'd1, "R11", "full-size packet not dropped", 64'(drop_cnt), 1);
        compare_out("R11");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        idle(1);
        wr_tbl(3'd0, 16'h0100, 1'b1);
        wr_tbl(3'd1, 16'h0100, 1'b1);
        wr_tbl(3'd2, 16'h0300, 1'b1);
        wr_tbl(3'd3, 16'h0333, 1'b0);
        wr_tbl(3'd4, 16'h0200, 1'b1);
        t_reset();
        t_basic();
        t_merge_interleave();
        t_ports();
        t_fifo_hold();
        t_invalid();
        t_overflow();
        t_full_packet();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule